// File: doc/BRIEF.md
# Waveform-Table Vector Formatter Channel

This block handles one pin of a digital test channel. It splits time into vector periods of a programmable number of clock ticks. At the first tick of each period it takes a character code and a table number. The selected table entry gives the character's meaning: one of eight drive or compare actions, two drive-edge tick positions and one receive-edge tick position. Edge 1 applies the decoded state. Edge 2 can apply a return level, so a single vector can form a return-to-zero pulse or a full clock pulse. The receive edge samples the pin and judges it against the expected state.

The block drives a data bit and an enable for the pin driver. One cycle after each period ends it reports a per-period verdict pulse and a fail flag. A sticky fail bit gathers those fails until software clears it. The tables are loaded through a plain write port while the channel is stopped.

Top module: `wavefmt_channel`

## Requirements
- R1: After reset, drv, drv_en, per_done, per_fail and fail_sticky are all 0, and the previous-level register is 0.
- R2: While en is high, each period lasts per_len clock ticks (per_len at least 2). vec_next is high exactly in tick 0. vec_tab and vec_chr are sampled only in that tick and are ignored in all other ticks.
- R3: A cfg_we write stores cfg_data at table cfg_tab, code cfg_chr (32 tables of 16 codes). Each vector uses only the entry in its own table. Entry layout: bits [2:0] action (0 U, 1 D, 2 P, 3 Z, 4 H, 5 L, 6 T, 7 X), bit 3 return enable, bit 4 return level, bits [12:5] edge-1 tick, [20:13] edge-2 tick, [28:21] receive tick.
- R4: At the edge-1 tick, U or D drive 1 or 0 with drv_en high. Z and all compare actions (H, L, T, X) release the driver. The outputs change in the cycle after that tick.
- R5: For U, D and P with return enable set, the edge-2 tick drives the return level with drv_en high. When edge 2 and edge 1 fall on the same tick, edge 2 wins.
- R6: P drives the level most recently applied by a U or D edge 1, carried across periods.
- R7: An edge whose tick equals per_len never fires in that period.
- R8: At the receive tick the pin is judged. H passes only on pin_z=0 and pin_in=1. L passes only on pin_z=0 and pin_in=0. T passes only on pin_z=1. X never fails. A receive tick of per_len gives no sample.
- R9: In the cycle after a period's last tick, per_done pulses. per_fail is high together with it if that period's sample failed.
- R10: fail_sticky is set in the cycle after per_fail and cleared in the cycle after fail_clr. If a set and a clear fall together, the set wins.
- R11: While en is low the tick counter is held at 0, no edge fires, the drive outputs hold and no verdict is made.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Run the period timer |
| per_len | input | 8 | Period length in ticks |
| vec_tab | input | 5 | Table select for the next vector |
| vec_chr | input | 4 | Character code for the next vector |
| vec_next | output | 1 | High in tick 0, when the vector inputs are taken |
| cfg_we | input | 1 | Table write strobe |
| cfg_tab | input | 5 | Table written |
| cfg_chr | input | 4 | Code written |
| cfg_data | input | 29 | Entry value |
| pin_in | input | 1 | Sensed pin level |
| pin_z | input | 1 | Sensed pin is high impedance |
| drv | output | 1 | Drive data |
| drv_en | output | 1 | Driver enable |
| per_done | output | 1 | Verdict pulse for the period just ended |
| per_fail | output | 1 | That period failed |
| fail_clr | input | 1 | Clear the sticky fail bit |
| fail_sticky | output | 1 | Sticky fail bit |

## Verification
Two events can fall in the same cycle: a period's fail pulse setting the sticky bit, and a software clear of that bit. The bench drives fail_clr at random while compare vectors run against random pin states, so the two meet many times. Each meeting is judged by expecting the bit set in the following cycle. Edge 1 and edge 2 on the same tick is forced by a directed vector whose return level differs from its decoded level, and the output must show the return level.

// File: rtl/wavefmt_channel.sv
module wavefmt_channel #(
  parameter int NTAB = 32,
  parameter int NCHR = 16,
  parameter int TW   = 8,
  localparam int TBW = $clog2(NTAB),
  localparam int CW  = $clog2(NCHR),
  localparam int EW  = 5 + 3 * TW
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           en,
  input  logic [TW-1:0]  per_len,
  input  logic [TBW-1:0] vec_tab,
  input  logic [CW-1:0]  vec_chr,
  output logic           vec_next,
  input  logic           cfg_we,
  input  logic [TBW-1:0] cfg_tab,
  input  logic [CW-1:0]  cfg_chr,
  input  logic [EW-1:0]  cfg_data,
  input  logic           pin_in,
  input  logic           pin_z,
  output logic           drv,
  output logic           drv_en,
  output logic           per_done,
  output logic           per_fail,
  input  logic           fail_clr,
  output logic           fail_sticky
);
  localparam logic [2:0] A_U = 3'd0, A_D = 3'd1, A_P = 3'd2, A_Z = 3'd3,
                         A_H = 3'd4, A_L = 3'd5, A_T = 3'd6;

  logic [EW-1:0]  tbl [NTAB*NCHR];
  logic [TW-1:0]  cnt;
  logic [TBW-1:0] h_tab;
  logic [CW-1:0]  h_chr;
  logic           last_lvl, acc;

  wire            first = en && cnt == '0;
  wire [TBW-1:0]  s_tab = first ? vec_tab : h_tab;
  wire [CW-1:0]   s_chr = first ? vec_chr : h_chr;
  wire [EW-1:0]   ent   = tbl[{s_tab, s_chr}];
  wire [2:0]      act   = ent[2:0];
  wire            ret_en  = ent[3];
  wire            ret_lvl = ent[4];
  wire [TW-1:0]   e1 = ent[5 +: TW];
  wire [TW-1:0]   e2 = ent[5 + TW +: TW];
  wire [TW-1:0]   rx = ent[5 + 2*TW +: TW];

  wire last_tick = cnt == per_len - 1'b1;
  wire hit1 = en && cnt == e1;
  wire hit2 = en && cnt == e2 && ret_en && act < A_Z;
  wire hitr = en && cnt == rx;

  logic miss;
  always_comb begin
    case (act)
      A_H:     miss = !(pin_in && !pin_z);
      A_L:     miss = !(!pin_in && !pin_z);
      A_T:     miss = !pin_z;
      default: miss = 1'b0;
    endcase
  end

  wire acc_n = (first ? 1'b0 : acc) | (hitr && miss);

  assign vec_next = first;

  always_ff @(posedge clk) begin
    if (cfg_we) tbl[{cfg_tab, cfg_chr}] <= cfg_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0; h_tab <= '0; h_chr <= '0; acc <= 1'b0;
      drv <= 1'b0; drv_en <= 1'b0; last_lvl <= 1'b0;
      per_done <= 1'b0; per_fail <= 1'b0; fail_sticky <= 1'b0;
    end else begin
      cnt <= !en ? '0 : last_tick ? '0 : cnt + 1'b1;
      if (first) begin
        h_tab <= vec_tab;
        h_chr <= vec_chr;
      end
      if (en) acc <= acc_n;
      per_done <= en && last_tick;
      per_fail <= en && last_tick && acc_n;
      if (hit1 && (act == A_U || act == A_D)) last_lvl <= (act == A_U);
      if (hit2) begin
        drv <= ret_lvl;
        drv_en <= 1'b1;
      end else if (hit1) begin
        case (act)
          A_U: begin drv <= 1'b1; drv_en <= 1'b1; end
          A_D: begin drv <= 1'b0; drv_en <= 1'b1; end
          A_P: begin drv <= last_lvl; drv_en <= 1'b1; end
          default: drv_en <= 1'b0;
        endcase
      end
      if (fail_clr) fail_sticky <= 1'b0;
      if (per_fail) fail_sticky <= 1'b1;
    end
  end

  AST_EDGE_RANGE: assert property (@(posedge clk) disable iff (rst)
    first |-> (e1 <= per_len && e2 <= per_len && rx <= per_len)); // R7
  AST_CNT_RANGE: assert property (@(posedge clk) disable iff (rst)
    en |-> cnt < per_len); // R2
  AST_Z_RELEASE: assert property (@(posedge clk) disable iff (rst)
    hit1 && act == A_Z |=> !drv_en); // R4
  AST_P_LEVEL: assert property (@(posedge clk) disable iff (rst)
    hit1 && act == A_P && !hit2 |=> drv_en && drv == $past(last_lvl)); // R6
  AST_FAIL_WITH_DONE: assert property (@(posedge clk) disable iff (rst)
    per_fail |-> per_done); // R9
  AST_STICKY_SET: assert property (@(posedge clk) disable iff (rst)
    per_fail |=> fail_sticky); // R10
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    !en |=> $stable(drv) && $stable(drv_en)); // R11
endmodule

// File: tb/test_wavefmt_channel.sv
module test_wavefmt_channel;
  localparam int TW = 8, EW = 29;
  logic clk = 0, rst = 1, en = 0;
  logic [TW-1:0] per_len = 8'd8;
  logic [4:0] vec_tab = 0, cfg_tab = 0;
  logic [3:0] vec_chr = 0, cfg_chr = 0;
  logic cfg_we = 0, pin_in = 0, pin_z = 0, fail_clr = 0;
  logic [EW-1:0] cfg_data = 0;
  logic vec_next, drv, drv_en, per_done, per_fail, fail_sticky;

  wavefmt_channel i_wavefmt_channel (.clk, .rst, .en, .per_len, .vec_tab, .vec_chr,
    .vec_next, .cfg_we, .cfg_tab, .cfg_chr, .cfg_data, .pin_in, .pin_z, .drv,
    .drv_en, .per_done, .per_fail, .fail_clr, .fail_sticky);

  always #10 clk = ~clk;

  int nchk = 0, nfail = 0, vecs = 0;
  bit finished = 0;
  logic [EW-1:0] tb_tbl [512];

  logic [TW-1:0] m_cnt; logic [4:0] m_tab; logic [3:0] m_chr;
  logic m_drv, m_en, m_last, m_acc, m_done, m_fail, m_sticky;
  string m_tag = "R4";

  function automatic logic [EW-1:0] mk(input int a, input bit re, input bit rl,
                                       input int e1, input int e2, input int rx);
    return {rx[7:0], e2[7:0], e1[7:0], rl, re, a[2:0]};
  endfunction

  function automatic bit exp_miss(input logic [2:0] a, input logic pi, input logic pz);
    case (a)
      3'd4: return !(pi && !pz);
      3'd5: return !(!pi && !pz);
      3'd6: return !pz;
      default: return 1'b0;
    endcase
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_cnt = 0; m_tab = 0; m_chr = 0; m_drv = 0; m_en = 0; m_last = 0;
      m_acc = 0; m_done = 0; m_fail = 0; m_sticky = 0;
    end else begin
      automatic bit first = en && m_cnt == 0;
      automatic logic [4:0] t = first ? vec_tab : m_tab;
      automatic logic [3:0] c = first ? vec_chr : m_chr;
      automatic logic [EW-1:0] e = tb_tbl[{t, c}];
      automatic logic [2:0] a = e[2:0];
      automatic bit lt = m_cnt == per_len - 1;
      automatic bit h1 = en && m_cnt == e[12:5];
      automatic bit h2 = en && m_cnt == e[20:13] && e[3] && a < 3;
      automatic bit hr = en && m_cnt == e[28:21];
      automatic bit accn = (first ? 1'b0 : m_acc) | (hr && exp_miss(a, pin_in, pin_z));
      if (fail_clr) m_sticky = 0;
      if (m_fail) m_sticky = 1;
      m_done = en && lt;
      m_fail = en && lt && accn;
      if (!en) m_tag = "R11";
      else if (first && (e[12:5] == per_len || e[20:13] == per_len)) m_tag = "R7";
      if (h2) begin
        m_drv = e[4]; m_en = 1; m_tag = "R5";
      end else if (h1) begin
        m_tag = (a == 2) ? "R6" : (t != 0 && a < 2) ? "R3" : "R4";
        if (a == 0) begin m_drv = 1; m_en = 1; end
        else if (a == 1) begin m_drv = 0; m_en = 1; end
        else if (a == 2) begin m_drv = m_last; m_en = 1; end
        else m_en = 0;
      end
      if (h1 && a < 2) m_last = (a == 0);
      if (en) m_acc = accn;
      if (first) begin m_tab = vec_tab; m_chr = vec_chr; end
      m_cnt = !en ? 8'd0 : lt ? 8'd0 : m_cnt + 1;
    end
  end

  task automatic check(input string tag, input logic act, input logic exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%0b expected=%0b t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    check("R2 vec_next", vec_next, en && m_cnt == 0);
    check({m_tag, " drv_en"}, drv_en, m_en);
    if (m_en) check({m_tag, " drv"}, drv, m_drv);
    check("R9 per_done", per_done, m_done);
    check("R8 per_fail", per_fail, m_fail);
    check("R10 fail_sticky", fail_sticky, m_sticky);
  endtask

  task automatic wr(input int t, input int c, input logic [EW-1:0] d);
    @(negedge clk);
    cfg_we = 1; cfg_tab = t[4:0]; cfg_chr = c[3:0]; cfg_data = d;
    tb_tbl[{t[4:0], c[3:0]}] = d;
    @(negedge clk);
    cfg_we = 0;
  endtask

  int dl_tab [13] = '{0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 5, 0};
  int dl_chr [13] = '{1, 2, 9, 2, 8, 3, 4, 5, 6, 7, 10, 1, 1};

  task automatic run(input int cycles, input bit directed);
    int idx = 0;
    for (int k = 0; k < cycles; k++) begin
      @(negedge clk);
      compare_all();
      pin_in = $urandom_range(0, 1);
      pin_z = ($urandom_range(0, 3) == 0);
      fail_clr = ($urandom_range(0, 7) == 0);
      if (vec_next) begin
        vecs++;
        idx++;
      end else if (directed) begin
        vec_tab = dl_tab[idx % 13][4:0];
        vec_chr = dl_chr[idx % 13][3:0];
      end else begin
        vec_tab = $urandom_range(0, 31);
        vec_chr = $urandom_range(0, 15);
      end
    end
  endtask

  initial begin
    int seed = $urandom(32'd2024);
    seed = 0;
    for (int i = 0; i < 512; i++) tb_tbl[i] = '0;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1 reset state
    check("R1 drv", drv, 1'b0);
    check("R1 drv_en", drv_en, 1'b0);
    check("R1 per_done", per_done, 1'b0);
    check("R1 per_fail", per_fail, 1'b0);
    check("R1 fail_sticky", fail_sticky, 1'b0);
    for (int i = 0; i < 512; i++)
      wr(i / 16, i % 16, mk($urandom_range(0, 7), $urandom_range(0, 1), $urandom_range(0, 1),
                           $urandom_range(0, 8), $urandom_range(0, 8), $urandom_range(0, 8)));
    // directed entries in table 0 and 5
    wr(0, 1, mk(0, 1, 0, 2, 5, 8));   // RZ pulse, R5
    wr(0, 2, mk(2, 0, 0, 0, 0, 8));   // P, R6
    wr(0, 3, mk(3, 0, 0, 1, 1, 8));   // Z, R4
    wr(0, 4, mk(4, 0, 0, 0, 0, 3));   // H, R8
    wr(0, 5, mk(5, 0, 0, 0, 0, 0));   // L at tick 0
    wr(0, 6, mk(6, 0, 0, 0, 0, 7));   // T at last tick
    wr(0, 7, mk(7, 0, 0, 0, 0, 4));   // X never fails
    wr(0, 8, mk(0, 1, 0, 8, 8, 8));   // edges at per_len, R7
    wr(0, 9, mk(1, 1, 1, 3, 3, 8));   // coincident edges, R5
    wr(0, 10, mk(4, 0, 0, 0, 0, 8));  // no sample, R8
    wr(5, 1, mk(1, 0, 0, 1, 1, 8));   // other table, R3
    per_len = 8;
    @(negedge clk);
    en = 1;
    run(8 * 13 * 4, 1'b1);
    for (int p = 0; p < 6; p++) begin
      @(negedge clk);
      en = 0;
      run(5, 1'b0);            // R11 idle hold
      per_len = 8'(8 + $urandom_range(0, 9));
      @(negedge clk);
      en = 1;
      run(2500, 1'b0);
    end
    en = 0;
    run(4, 1'b0);
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, nfail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      nfail++;
      $display("FAIL R2 watchdog actual=running expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", vecs, nfail);
      $finish;
    end
  end
endmodule